// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a set of timer channels and the interrupt fabric. Each channel reports expiry with a one-cycle pulse. The router turns that pulse into one of three effects. A level-type channel latches a status bit and holds its interrupt line high. An edge-type channel pulses its line for one cycle. A channel set for message signalling issues a single 32-bit memory-write request instead of touching any line.

Software clears latched status by writing ones to the status write port. A channel can also be cleared directly, for example when its timer is switched off.

A global legacy-replacement mode overrides the normal routing:
- It hard-wires channel 0 to line 0 and channel 1 to line 8.
- It cuts the pass-through of two external legacy interrupt inputs, the interval-timer interrupt and the real-time-clock interrupt, which otherwise reach those same two lines.
- It drives low an enable output for the external interval timer.

Every output is registered. Each result therefore appears exactly one clock after the stimulus that causes it.

Top module: `tir_router`

## Requirements
- R1: After reset, `sts` is 0, all `irq_lines` are low, `msg_valid` is low and `pit_en` is high.
- R2: The routed line index is the channel's 4-bit `ch_route` field (channel c at bits [4c+3:4c]). The exception is legacy mode (`legacy_en`=1): there channel 0 goes to line 0 and channel 1 to line 8, whatever their fields hold.
- R3: An expiry on a channel that meets all of the following sets its status bit one cycle later and holds its routed line high until the bit is cleared: the channel is enabled, `glb_en` is 1, `ch_msg_en` is 0 and `ch_level` is 1.
- R4: An expiry on an enabled edge-type channel (`ch_level`=0, `ch_msg_en`=0) raises its routed line for exactly one cycle and leaves its status bit 0.
- R5: An expiry while `ch_en` is 0 or `glb_en` is 0 leaves the status bit 0 and the line low. A `clr_req` pulse clears the channel's status bit and lowers its line one cycle later.
- R6: An expiry on an enabled channel with `ch_msg_en`=1 drives no line. One cycle later it gives a one-cycle `msg_valid`, with `msg_addr` taken from bits [63:32] and `msg_data` from bits [31:0] of that channel's 64-bit `ch_msg_word` slice. If several channels fire together, the lowest-numbered one is sent.
- R7: A write on the status port (`sts_wr`=1) clears exactly those status bits where both `sts_wdata` and the current status are 1. Lines fed only by the cleared channels go low in the same cycle as the bit.
- R8: A rising edge of a channel's `ch_msg_en` clears that channel's pending status bit one cycle later.
- R9: `pit_en` equals the inverse of `legacy_en`, one cycle later. While `legacy_en` is 0, `pit_in` reaches line 0 and `rtc_in` reaches line 8 one cycle later. While it is 1, both inputs are masked.
- R10: When several channels route to one line, the line is high while any of their level requests is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt-generation enable |
| legacy_en | input | 1 | Legacy-replacement routing mode |
| ch_en | input | N_CH | Per-channel enable |
| ch_level | input | N_CH | Trigger type per channel, 1 = level, 0 = edge |
| ch_msg_en | input | N_CH | Per-channel message signalling enable |
| ch_route | input | N_CH*RW | Per-channel line index, RW bits each |
| ch_msg_word | input | N_CH*64 | Per-channel message word: address high half, data low half |
| expire | input | N_CH | One-cycle expiry pulses |
| clr_req | input | N_CH | Per-channel clear request |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | N_CH | Write-one-to-clear mask |
| pit_in | input | 1 | External interval-timer interrupt level |
| rtc_in | input | 1 | External real-time-clock interrupt level |
| irq_lines | output | N_LINES | Interrupt line levels |
| sts | output | N_CH | Latched status bits |
| pit_en | output | 1 | Interval-timer enable |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Each result is due one clock after its cause, because lines, status, the message request and `pit_en` are all updated by the same edge that samples the stimulus. The bench changes inputs on the falling edge and samples one falling edge later, so every check lands in the cycle the result is due. The edge-type pulse is also checked one cycle after that, to confirm it is gone. Sticky effects such as the status-write clear and the message-enable clear are checked in the cycle after the causing write, before any further stimulus is applied.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int unsigned MSG_W = 32;

  typedef struct packed {
    logic             valid;
    logic [MSG_W-1:0] addr;
    logic [MSG_W-1:0] data;
  } msg_wr_t;
endpackage

// File: rtl/tir_status_bank.sv
module tir_status_bank #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glb_en,
  input  logic [N_CH-1:0] ch_en,
  input  logic [N_CH-1:0] ch_level,
  input  logic [N_CH-1:0] ch_msg_en,
  input  logic [N_CH-1:0] expire,
  input  logic [N_CH-1:0] clr_req,
  input  logic            sts_wr,
  input  logic [N_CH-1:0] sts_wdata,
  output logic [N_CH-1:0] sts_q,
  output logic [N_CH-1:0] sts_d,
  output logic [N_CH-1:0] edge_fire,
  output logic [N_CH-1:0] msg_fire
);
  logic [N_CH-1:0] msg_q;
  logic [N_CH-1:0] en_ok;
  logic [N_CH-1:0] set_v;
  logic [N_CH-1:0] clr_v;
  logic [N_CH-1:0] upd;

  always_comb begin
    en_ok     = ch_en & {N_CH{glb_en}};
    set_v     = expire & en_ok & ~ch_msg_en & ch_level;
    edge_fire = expire & en_ok & ~ch_msg_en & ~ch_level;
    msg_fire  = expire & en_ok & ch_msg_en;
    clr_v     = (expire & ~(en_ok & ch_msg_en))
              | clr_req
              | (sts_wdata & {N_CH{sts_wr}})
              | (ch_msg_en & ~msg_q);
    upd       = set_v | clr_v;
    sts_d     = set_v | (sts_q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msg_q <= '0;
    end else begin
      msg_q <= ch_msg_en;
      for (int i = 0; i < N_CH; i++) begin
        if (upd[i]) sts_q[i] <= sts_d[i];
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && ch_en[g] && glb_en && !ch_msg_en[g] && ch_level[g]) |=> sts_q[g]); // R3
    AST_EDGE_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && ch_en[g] && glb_en && !ch_msg_en[g] && !ch_level[g]) |=> !sts_q[g]); // R4
    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && !(ch_en[g] && glb_en)) |=> !sts_q[g]); // R5
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && sts_wdata[g] && !(expire[g] && ch_level[g])) |=> !sts_q[g]); // R7
    AST_MSG_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_msg_en[g] && !msg_q[g]) |=> !sts_q[g]); // R8
  end
endmodule

// File: rtl/tir_line_mux.sv
module tir_line_mux #(
  parameter int N_CH     = 4,
  parameter int N_LINES  = 16,
  parameter int PIT_LINE = 0,
  parameter int RTC_LINE = 8,
  localparam int RW      = $clog2(N_LINES)
) (
  input  logic              legacy_en,
  input  logic [N_CH*RW-1:0] ch_route,
  input  logic [N_CH-1:0]   ch_msg_en,
  input  logic [N_CH-1:0]   lvl_req,
  input  logic [N_CH-1:0]   edge_fire,
  input  logic              pit_in,
  input  logic              rtc_in,
  output logic [N_LINES-1:0] lines_d
);
  logic [RW-1:0] eff [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_route
    if (c == 0) begin : g_c0
      assign eff[c] = legacy_en ? RW'(PIT_LINE) : ch_route[c*RW +: RW];
    end else if (c == 1) begin : g_c1
      assign eff[c] = legacy_en ? RW'(RTC_LINE) : ch_route[c*RW +: RW];
    end else begin : g_cn
      assign eff[c] = ch_route[c*RW +: RW];
    end
  end

  always_comb begin
    lines_d = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (((lvl_req[c] && !ch_msg_en[c]) || edge_fire[c]) && (int'(eff[c]) < N_LINES))
        lines_d[eff[c]] = 1'b1;
    end
    if (!legacy_en) begin
      lines_d[PIT_LINE] = lines_d[PIT_LINE] | pit_in;
      lines_d[RTC_LINE] = lines_d[RTC_LINE] | rtc_in;
    end
  end
endmodule

// File: rtl/tir_msg_sel.sv
module tir_msg_sel
  import tir_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0]         msg_fire,
  input  logic [N_CH*2*MSG_W-1:0] ch_msg_word,
  output msg_wr_t                 msg_d
);
  always_comb begin
    msg_d = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (msg_fire[i]) begin
        msg_d.valid = 1'b1;
        msg_d.data  = ch_msg_word[i*2*MSG_W +: MSG_W];
        msg_d.addr  = ch_msg_word[i*2*MSG_W + MSG_W +: MSG_W];
      end
    end
  end
endmodule

// File: rtl/tir_router.sv
module tir_router
  import tir_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int N_LINES  = 16,
  parameter int PIT_LINE = 0,
  parameter int RTC_LINE = 8,
  localparam int RW      = $clog2(N_LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic                    legacy_en,
  input  logic [N_CH-1:0]         ch_en,
  input  logic [N_CH-1:0]         ch_level,
  input  logic [N_CH-1:0]         ch_msg_en,
  input  logic [N_CH*RW-1:0]      ch_route,
  input  logic [N_CH*2*MSG_W-1:0] ch_msg_word,
  input  logic [N_CH-1:0]         expire,
  input  logic [N_CH-1:0]         clr_req,
  input  logic                    sts_wr,
  input  logic [N_CH-1:0]         sts_wdata,
  input  logic                    pit_in,
  input  logic                    rtc_in,
  output logic [N_LINES-1:0]      irq_lines,
  output logic [N_CH-1:0]         sts,
  output logic                    pit_en,
  output logic                    msg_valid,
  output logic [MSG_W-1:0]        msg_addr,
  output logic [MSG_W-1:0]        msg_data
);
  logic [N_CH-1:0]    sts_d;
  logic [N_CH-1:0]    edge_fire;
  logic [N_CH-1:0]    msg_fire;
  logic [N_LINES-1:0] lines_d;
  msg_wr_t            msg_d;

  tir_status_bank #(.N_CH(N_CH)) i_status (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_en(ch_en),
    .ch_level(ch_level), .ch_msg_en(ch_msg_en), .expire(expire),
    .clr_req(clr_req), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .sts_q(sts), .sts_d(sts_d), .edge_fire(edge_fire), .msg_fire(msg_fire)
  );

  tir_line_mux #(.N_CH(N_CH), .N_LINES(N_LINES), .PIT_LINE(PIT_LINE),
                 .RTC_LINE(RTC_LINE)) i_lines (
    .legacy_en(legacy_en), .ch_route(ch_route), .ch_msg_en(ch_msg_en),
    .lvl_req(sts_d), .edge_fire(edge_fire), .pit_in(pit_in),
    .rtc_in(rtc_in), .lines_d(lines_d)
  );

  tir_msg_sel #(.N_CH(N_CH)) i_msg (
    .msg_fire(msg_fire), .ch_msg_word(ch_msg_word), .msg_d(msg_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_lines <= '0;
      pit_en    <= 1'b1;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      irq_lines <= lines_d;
      pit_en    <= ~legacy_en;
      msg_valid <= msg_d.valid;
      if (msg_d.valid) begin
        msg_addr <= msg_d.addr;
        msg_data <= msg_d.data;
      end
    end
  end

  AST_PIT_OFF_IN_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_en |=> !pit_en); // R9
  AST_PIT_ON_OUT_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_en |=> pit_en); // R9
  AST_MSG_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(|msg_fire)); // R6
  AST_MSG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|msg_fire) |=> !msg_valid); // R6
endmodule

// File: tb/test_tir_router.sv
module test_tir_router;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         glb_en, legacy_en;
  logic [3:0]   ch_en, ch_level, ch_msg_en, expire, clr_req, sts_wdata;
  logic [15:0]  ch_route;
  logic [255:0] ch_msg_word;
  logic         sts_wr, pit_in, rtc_in;
  logic [15:0]  irq_lines;
  logic [3:0]   sts;
  logic         pit_en, msg_valid;
  logic [31:0]  msg_addr, msg_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tir_router i_tir_router (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_en(legacy_en),
    .ch_en(ch_en), .ch_level(ch_level), .ch_msg_en(ch_msg_en),
    .ch_route(ch_route), .ch_msg_word(ch_msg_word), .expire(expire),
    .clr_req(clr_req), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .pit_in(pit_in), .rtc_in(rtc_in), .irq_lines(irq_lines), .sts(sts),
    .pit_en(pit_en), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  // row: {ch[2], level, msg, route[4], legacy, exp_lines[16], exp_sts[4], exp_msg}
  localparam logic [29:0] VEC [6] = '{
    {2'd2, 1'b1, 1'b0, 4'd5, 1'b0, 16'h0020, 4'b0100, 1'b0},  // R2 R3
    {2'd1, 1'b0, 1'b0, 4'd3, 1'b0, 16'h0008, 4'b0000, 1'b0},  // R4
    {2'd0, 1'b1, 1'b0, 4'd7, 1'b1, 16'h0001, 4'b0001, 1'b0},  // R2 legacy ch0
    {2'd1, 1'b1, 1'b0, 4'd3, 1'b1, 16'h0100, 4'b0010, 1'b0},  // R2 legacy ch1
    {2'd3, 1'b1, 1'b0, 4'd9, 1'b1, 16'h0200, 4'b1000, 1'b0},  // R2 others keep field
    {2'd2, 1'b1, 1'b1, 4'd5, 1'b0, 16'h0000, 4'b0000, 1'b1}   // R6
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    sts_wr = 1'b1; sts_wdata = 4'hF;
    step();
    sts_wr = 1'b0; sts_wdata = 4'h0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [29:0] v;
    int          ch;
    rst_n = 1'b0; glb_en = 1'b1; legacy_en = 1'b0;
    ch_en = 4'hF; ch_level = 4'h0; ch_msg_en = 4'h0;
    ch_route = {4'd13, 4'd12, 4'd11, 4'd10};
    ch_msg_word = '0; expire = '0; clr_req = '0;
    sts_wr = 1'b0; sts_wdata = '0; pit_in = 1'b0; rtc_in = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 sts after reset", sts, 0);
    chk("R1 lines after reset", irq_lines, 0);
    chk("R1 msg_valid after reset", msg_valid, 0);
    chk("R1 pit_en after reset", pit_en, 1);

    // table walk
    for (int k = 0; k < 6; k++) begin
      v  = VEC[k];
      ch = int'(v[29:28]);
      ch_level[ch]  = v[27];
      ch_msg_en[ch] = v[26];
      ch_route[ch*4 +: 4] = v[25:22];
      legacy_en = v[21];
      expire = 4'b0001 << ch;
      step();
      chk($sformatf("R2/R3/R4/R6 row %0d lines", k), irq_lines, v[20:5]);
      chk($sformatf("R3/R4 row %0d sts", k), sts, v[4:1]);
      chk($sformatf("R6 row %0d msg_valid", k), msg_valid, v[0]);
      expire = '0; legacy_en = 1'b0; ch_msg_en = '0; ch_level = '0;
      ch_route = {4'd13, 4'd12, 4'd11, 4'd10};
      clear_all();
    end

    // R4: edge pulse lasts exactly one cycle
    ch_route[4 +: 4] = 4'd3; expire = 4'b0010;
    step();
    expire = '0;
    chk("R4 edge line high", irq_lines, 16'h0008);
    step();
    chk("R4 edge line gone next cycle", irq_lines, 0);
    chk("R4 edge sts stays 0", sts, 0);
    ch_route = {4'd13, 4'd12, 4'd11, 4'd10};

    // R6: message write, lowest channel wins
    ch_msg_word[0*64 +: 64] = 64'h1234_0000_0000_00AA;
    ch_msg_word[2*64 +: 64] = 64'hFEE0_1000_0000_0041;
    ch_level = 4'b0101; ch_msg_en = 4'b0101;
    step();
    expire = 4'b0101;
    step();
    expire = '0;
    chk("R6 msg_valid", msg_valid, 1);
    chk("R6 lowest addr", msg_addr, 32'h1234_0000);
    chk("R6 lowest data", msg_data, 32'h0000_00AA);
    chk("R6 no line", irq_lines, 0);
    chk("R6 no status", sts, 0);
    step();
    chk("R6 one cycle valid", msg_valid, 0);
    expire = 4'b0100;
    step();
    expire = '0;
    chk("R6 ch2 addr", msg_addr, 32'hFEE0_1000);
    chk("R6 ch2 data", msg_data, 32'h0000_0041);
    ch_msg_en = '0; ch_level = '0;
    step();

    // R5: disabled channel, global off, clear request
    ch_level = 4'hF; ch_en = 4'b1110; ch_route[0 +: 4] = 4'd4; expire = 4'b0001;
    step();
    expire = '0;
    chk("R5 disabled ch sts", sts, 0);
    chk("R5 disabled ch line", irq_lines, 0);
    ch_en = 4'hF; glb_en = 1'b0; expire = 4'b0100;
    step();
    expire = '0;
    chk("R5 global off sts", sts, 0);
    chk("R5 global off line", irq_lines, 0);
    glb_en = 1'b1; expire = 4'b0100;
    step();
    expire = '0;
    chk("R3 ch2 set before clr", sts, 4'b0100);
    chk("R3 line12 high", irq_lines, 16'h1000);
    clr_req = 4'b0100;
    step();
    clr_req = '0;
    chk("R5 clr_req sts", sts, 0);
    chk("R5 clr_req line", irq_lines, 0);
    ch_route = {4'd13, 4'd12, 4'd11, 4'd10};

    // R7: partial write-one-to-clear
    ch_route[0 +: 4] = 4'd6; expire = 4'b0101;
    step();
    expire = '0;
    chk("R7 setup sts", sts, 4'b0101);
    sts_wr = 1'b1; sts_wdata = 4'b0001;
    step();
    chk("R7 bit0 cleared", sts, 4'b0100);
    chk("R7 line6 low line12 high", irq_lines, 16'h1000);
    sts_wdata = 4'b0010;
    step();
    sts_wr = 1'b0; sts_wdata = '0;
    chk("R7 write to clear bit no effect", sts, 4'b0100);
    chk("R7 lines unchanged", irq_lines, 16'h1000);
    clear_all();

    // R10: shared line
    ch_route[0 +: 4] = 4'd6; ch_route[12 +: 4] = 4'd6; expire = 4'b1001;
    step();
    expire = '0;
    chk("R10 both pending", irq_lines, 16'h0040);
    sts_wr = 1'b1; sts_wdata = 4'b0001;
    step();
    chk("R10 line held by ch3", irq_lines, 16'h0040);
    sts_wdata = 4'b1000;
    step();
    sts_wr = 1'b0; sts_wdata = '0;
    chk("R10 line low when none", irq_lines, 0);
    ch_route = {4'd13, 4'd12, 4'd11, 4'd10};

    // R8: message enable rise clears pending
    expire = 4'b0010;
    step();
    expire = '0;
    chk("R8 setup sts", sts, 4'b0010);
    ch_msg_en = 4'b0010;
    step();
    chk("R8 sts cleared", sts, 0);
    chk("R8 line low", irq_lines, 0);
    ch_msg_en = '0; ch_level = '0;
    step();

    // R9: legacy pass-through and pit_en
    pit_in = 1'b1; rtc_in = 1'b1;
    step();
    chk("R9 pass-through", irq_lines, 16'h0101);
    chk("R9 pit_en high", pit_en, 1);
    legacy_en = 1'b1;
    step();
    chk("R9 masked in legacy", irq_lines, 0);
    chk("R9 pit_en low", pit_en, 0);
    legacy_en = 1'b0;
    step();
    chk("R9 restored after legacy", irq_lines, 16'h0101);
    chk("R9 pit_en back high", pit_en, 1);
    pit_in = 1'b0; rtc_in = 1'b0;
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule